// File: doc/BRIEF.md
# Windowed Link Throughput Monitor

This block watches one memory link in both directions and measures how much useful data moved across it during a measurement window. Every core clock cycle each direction delivers a beat of up to four FLIT lanes. Each lane has a valid flag and a start-of-packet flag. A lane that starts a packet also carries a 2-bit size class that gives the packet's data payload.

While the window is open the block does four things. It counts elapsed cycles. For each direction it counts valid FLITs and counts request packets per payload size. It also accumulates the payload data bits those packets carry. Header and tail FLITs therefore add nothing to the bit total. Software divides the bit total by the cycle count and the clock period to get effective bandwidth.

A window opens on a start pulse, which clears every counter in the same cycle. It closes on a stop pulse or, in limited mode, after a programmed number of cycles. Once closed, the results stay frozen and a done flag is set.

Top module: `link_tput_meter`

## Requirements
- R1: After reset every counter reads zero, and `done` and `running` are both 0.
- R2: A `start` pulse clears every counter and opens the window in a single cycle, so `running` is 1 and `done` is 0 in the next cycle. Traffic presented in the start cycle is not counted. `start` also restarts a window that is already open, and it takes priority over a `stop` in the same cycle.
- R3: In each counted cycle the FLIT counter of a direction grows by the number of set bits in that direction's valid mask, which ranges from 0 to 4.
- R4: A lane counts as a request when both its valid bit and its start-of-packet bit are set. Its class is read from bits [2i+1:2i] of the class port: 0 means 16 bytes, 1 means 32, 2 means 64 and 3 means 128. Class k's count sits at bits [k*W +: W] of the request port. A start-of-packet flag on an invalid lane is ignored.
- R5: Each counted request adds 128 << class payload bits (128, 256, 512 or 1024) to its direction's bit counter. Lanes without a start-of-packet flag add no bits.
- R6: The cycle counter grows by one in each counted cycle. A counted cycle is one where the window is open and neither `start` nor `stop` is asserted. Beats in the stop cycle are not counted.
- R7: A `stop` while the window is open closes it. From the next cycle `done` is 1, `running` is 0, and every counter holds its value under any further traffic. A `stop` while the window is closed has no effect.
- R8: With `limit_en` set and a limit L of 1 or more, the window covers exactly L counted cycles and then closes with `done` set. A limit of 0 behaves as 1.
- R9: Every counter saturates at 2^W-1 instead of wrapping.
- R10: The transmit and receive directions are counted independently, so traffic on one never changes the other's counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: clear counters and open a window |
| stop | input | 1 | Pulse: close the open window |
| limit_en | input | 1 | Close the window automatically after `cycle_limit` cycles |
| cycle_limit | input | W | Window length in cycles for limited mode |
| tx_vld | input | LANES | Transmit lane valid mask |
| tx_sop | input | LANES | Transmit lane start-of-packet mask |
| tx_cls | input | 2*LANES | Transmit size class, 2 bits per lane |
| rx_vld | input | LANES | Receive lane valid mask |
| rx_sop | input | LANES | Receive lane start-of-packet mask |
| rx_cls | input | 2*LANES | Receive size class, 2 bits per lane |
| running | output | 1 | Window is open |
| done | output | 1 | Window closed, results frozen |
| cycle_cnt | output | W | Counted cycles |
| tx_flit_cnt | output | W | Transmit FLITs |
| rx_flit_cnt | output | W | Receive FLITs |
| tx_req_cnt | output | 4*W | Transmit requests per size class |
| rx_req_cnt | output | 4*W | Receive requests per size class |
| tx_bit_cnt | output | W | Transmit payload bits |
| rx_bit_cnt | output | W | Receive payload bits |

## Verification
The bench sends traffic in the start cycle and in the stop cycle. A design that counted the boundary beats would come out with FLIT and cycle totals one beat too high. It also places start-of-packet flags on invalid lanes and mixes every size class within a single beat. A decoder that ignored the valid bit, or shifted the class to the wrong weight, would inflate both the request counts and the bit totals. Limited windows of 5 and 0 cycles catch off-by-one endings, and a restart and a same-cycle start and stop catch a wrong priority. A narrow-width instance is pushed past its maximum to show that a wrapping counter would fall back to a small value.

// File: rtl/tput_pkg.sv
package tput_pkg;

    // Payload size classes carried on a start-of-packet lane
    typedef enum logic [1:0] {
        SZ_16B  = 2'd0,
        SZ_32B  = 2'd1,
        SZ_64B  = 2'd2,
        SZ_128B = 2'd3
    } size_cls_e;

    localparam int NUM_CLS          = 4;
    localparam int MIN_PAYLOAD_BITS = 128;
    localparam int MAX_PAYLOAD_BITS = MIN_PAYLOAD_BITS << (NUM_CLS - 1);
    localparam int PBITS_W          = $clog2(MAX_PAYLOAD_BITS + 1);

    // Data bits carried by one request of the given class
    function automatic logic [PBITS_W-1:0] payload_bits(input size_cls_e c);
        return PBITS_W'(MIN_PAYLOAD_BITS) << c;
    endfunction

endpackage

// File: rtl/tput_beat_decode.sv
module tput_beat_decode
    import tput_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int NF_W   = $clog2(LANES + 1),
    parameter int BITS_W = $clog2(LANES * MAX_PAYLOAD_BITS + 1)
) (
    input  logic [LANES-1:0]        vld,
    input  logic [LANES-1:0]        sop,
    input  logic [2*LANES-1:0]      cls,
    output logic [NF_W-1:0]         nflits,
    output logic [NUM_CLS*NF_W-1:0] req,
    output logic [BITS_W-1:0]       bits
);

    always_comb begin
        nflits = '0;
        req    = '0;
        bits   = '0;
        for (int i = 0; i < LANES; i++) begin
            nflits = nflits + NF_W'(vld[i]);
            if (vld[i] && sop[i]) begin
                bits = bits + BITS_W'(payload_bits(size_cls_e'(cls[2*i +: 2])));
                for (int k = 0; k < NUM_CLS; k++) begin
                    if (cls[2*i +: 2] == k[1:0])
                        req[k*NF_W +: NF_W] = req[k*NF_W +: NF_W] + NF_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tput_sat_acc.sv
module tput_sat_acc #(
    parameter int W  = 48,
    parameter int IW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  value
);

    localparam int SW = ((W > IW) ? W : IW) + 1;

    logic [SW-1:0] sum_w;
    logic [SW-1:0] max_w;

    assign max_w = {{(SW-W){1'b0}}, {W{1'b1}}};
    assign sum_w = {{(SW-W){1'b0}}, value} + {{(SW-IW){1'b0}}, inc};

    always_ff @(posedge clk) begin
        if (rst || clr)
            value <= '0;
        else if (en)
            value <= (sum_w > max_w) ? {W{1'b1}} : sum_w[W-1:0];
    end

    // R9: a counter at its maximum stays there until cleared
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && value == {W{1'b1}}) |=> value == {W{1'b1}});

    // R9: without a clear the value never decreases, so it never wraps
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        !clr |=> value >= $past(value));

endmodule

// File: rtl/tput_window_ctrl.sv
module tput_window_ctrl #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         stop,
    input  logic         limit_en,
    input  logic [W-1:0] cycle_limit,
    input  logic [W-1:0] cycles,
    output logic         clr,
    output logic         count_en,
    output logic         running,
    output logic         done
);

    logic         lim_hit;
    logic [W:0]   cyc_next;

    assign clr      = start;
    assign count_en = running && !start && !stop;
    assign cyc_next = {1'b0, cycles} + (W+1)'(1);
    assign lim_hit  = count_en && limit_en && (cyc_next >= {1'b0, cycle_limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            done    <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            done    <= 1'b0;
        end else if (running && (stop || lim_hit)) begin
            running <= 1'b0;
            done    <= 1'b1;
        end
    end

    // R7: a closed window is never also open
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !running);

    // R8: a counted cycle that reaches the limit closes the window
    p_limit_end_r8: assert property (@(posedge clk) disable iff (rst)
        (count_en && limit_en && cyc_next >= {1'b0, cycle_limit}) |=> (done && !running));

endmodule

// File: rtl/link_tput_meter.sv
module link_tput_meter
    import tput_pkg::*;
#(
    parameter int W     = 48,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   stop,
    input  logic                   limit_en,
    input  logic [W-1:0]           cycle_limit,
    input  logic [LANES-1:0]       tx_vld,
    input  logic [LANES-1:0]       tx_sop,
    input  logic [2*LANES-1:0]     tx_cls,
    input  logic [LANES-1:0]       rx_vld,
    input  logic [LANES-1:0]       rx_sop,
    input  logic [2*LANES-1:0]     rx_cls,
    output logic                   running,
    output logic                   done,
    output logic [W-1:0]           cycle_cnt,
    output logic [W-1:0]           tx_flit_cnt,
    output logic [W-1:0]           rx_flit_cnt,
    output logic [NUM_CLS*W-1:0]   tx_req_cnt,
    output logic [NUM_CLS*W-1:0]   rx_req_cnt,
    output logic [W-1:0]           tx_bit_cnt,
    output logic [W-1:0]           rx_bit_cnt
);

    localparam int NF_W   = $clog2(LANES + 1);
    localparam int BITS_W = $clog2(LANES * MAX_PAYLOAD_BITS + 1);

    logic                   clr;
    logic                   count_en;
    logic [NF_W-1:0]        tx_nf,  rx_nf;
    logic [NUM_CLS*NF_W-1:0] tx_rq, rx_rq;
    logic [BITS_W-1:0]      tx_bits, rx_bits;

    tput_window_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .limit_en(limit_en), .cycle_limit(cycle_limit), .cycles(cycle_cnt),
        .clr(clr), .count_en(count_en), .running(running), .done(done)
    );

    tput_beat_decode #(.LANES(LANES), .NF_W(NF_W), .BITS_W(BITS_W)) u_tx_dec (
        .vld(tx_vld), .sop(tx_sop), .cls(tx_cls),
        .nflits(tx_nf), .req(tx_rq), .bits(tx_bits)
    );

    tput_beat_decode #(.LANES(LANES), .NF_W(NF_W), .BITS_W(BITS_W)) u_rx_dec (
        .vld(rx_vld), .sop(rx_sop), .cls(rx_cls),
        .nflits(rx_nf), .req(rx_rq), .bits(rx_bits)
    );

    tput_sat_acc #(.W(W), .IW(1)) u_cyc (
        .clk(clk), .rst(rst), .clr(clr), .en(count_en), .inc(1'b1), .value(cycle_cnt)
    );

    tput_sat_acc #(.W(W), .IW(NF_W)) u_tx_flit (
        .clk(clk), .rst(rst), .clr(clr), .en(count_en), .inc(tx_nf), .value(tx_flit_cnt)
    );

    tput_sat_acc #(.W(W), .IW(NF_W)) u_rx_flit (
        .clk(clk), .rst(rst), .clr(clr), .en(count_en), .inc(rx_nf), .value(rx_flit_cnt)
    );

    tput_sat_acc #(.W(W), .IW(BITS_W)) u_tx_bits (
        .clk(clk), .rst(rst), .clr(clr), .en(count_en), .inc(tx_bits), .value(tx_bit_cnt)
    );

    tput_sat_acc #(.W(W), .IW(BITS_W)) u_rx_bits (
        .clk(clk), .rst(rst), .clr(clr), .en(count_en), .inc(rx_bits), .value(rx_bit_cnt)
    );

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
        tput_sat_acc #(.W(W), .IW(NF_W)) u_tx_req (
            .clk(clk), .rst(rst), .clr(clr), .en(count_en),
            .inc(tx_rq[k*NF_W +: NF_W]), .value(tx_req_cnt[k*W +: W])
        );
        tput_sat_acc #(.W(W), .IW(NF_W)) u_rx_req (
            .clk(clk), .rst(rst), .clr(clr), .en(count_en),
            .inc(rx_rq[k*NF_W +: NF_W]), .value(rx_req_cnt[k*W +: W])
        );
    end

    // R2: the cycle after start shows a cleared, open window
    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (running && !done && cycle_cnt == '0 && tx_flit_cnt == '0 &&
                   rx_flit_cnt == '0 && tx_bit_cnt == '0 && rx_bit_cnt == '0));

    // R7: a closed window keeps its results under any traffic
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> ($stable(cycle_cnt) && $stable(tx_flit_cnt) &&
            $stable(rx_flit_cnt) && $stable(tx_bit_cnt) && $stable(rx_bit_cnt) &&
            $stable(tx_req_cnt) && $stable(rx_req_cnt)));

endmodule

// File: tb/sim_link_tput_meter.sv
module sim_link_tput_meter;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 48;
    localparam int SW = 12;
    localparam longint unsigned MAXV = (64'd1 << W) - 64'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic           start = 0, stop = 0, limit_en = 0;
    logic [W-1:0]   cycle_limit = '0;
    logic [3:0]     tx_vld = 0, tx_sop = 0, rx_vld = 0, rx_sop = 0;
    logic [7:0]     tx_cls = 0, rx_cls = 0;
    logic           running, done;
    logic [W-1:0]   cycle_cnt, tx_flit_cnt, rx_flit_cnt, tx_bit_cnt, rx_bit_cnt;
    logic [4*W-1:0] tx_req_cnt, rx_req_cnt;

    link_tput_meter u0 (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .limit_en(limit_en),
        .cycle_limit(cycle_limit), .tx_vld(tx_vld), .tx_sop(tx_sop), .tx_cls(tx_cls),
        .rx_vld(rx_vld), .rx_sop(rx_sop), .rx_cls(rx_cls), .running(running), .done(done),
        .cycle_cnt(cycle_cnt), .tx_flit_cnt(tx_flit_cnt), .rx_flit_cnt(rx_flit_cnt),
        .tx_req_cnt(tx_req_cnt), .rx_req_cnt(rx_req_cnt),
        .tx_bit_cnt(tx_bit_cnt), .rx_bit_cnt(rx_bit_cnt)
    );

    // Narrow instance used to reach saturation
    logic            s_start = 0;
    logic [3:0]      s_vld = 0, s_sop = 0;
    logic [7:0]      s_cls = 0;
    logic            s_running, s_done;
    logic [SW-1:0]   s_cyc, s_txf, s_rxf, s_txb, s_rxb;
    logic [4*SW-1:0] s_txr, s_rxr;

    link_tput_meter #(.W(SW)) u1 (
        .clk(clk), .rst(rst), .start(s_start), .stop(1'b0), .limit_en(1'b0),
        .cycle_limit('0), .tx_vld(s_vld), .tx_sop(s_sop), .tx_cls(s_cls),
        .rx_vld(4'b0), .rx_sop(4'b0), .rx_cls(8'b0), .running(s_running), .done(s_done),
        .cycle_cnt(s_cyc), .tx_flit_cnt(s_txf), .rx_flit_cnt(s_rxf),
        .tx_req_cnt(s_txr), .rx_req_cnt(s_rxr), .tx_bit_cnt(s_txb), .rx_bit_cnt(s_rxb)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model state
    typedef struct {
        string           tag;
        longint unsigned cyc, txf, rxf, txb, rxb;
        longint unsigned txr [4];
        longint unsigned rxr [4];
        bit              run, dn;
    } exp_t;

    exp_t m;
    exp_t sbq [$];

    function automatic longint unsigned sat(input longint unsigned a, input longint unsigned b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    function automatic int ones(input logic [3:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
    endfunction

    task automatic model_dir(input logic [3:0] v, input logic [3:0] s, input logic [7:0] c,
                             inout longint unsigned f, inout longint unsigned b,
                             inout longint unsigned r [4]);
        f = sat(f, longint'(ones(v)));
        for (int i = 0; i < 4; i++) begin
            if (v[i] && s[i]) begin
                r[c[2*i +: 2]] = sat(r[c[2*i +: 2]], 1);
                b = sat(b, 64'd128 << c[2*i +: 2]);
            end
        end
    endtask

    // One clock of stimulus; called just after a falling edge
    task automatic step(input logic st, input logic sp,
                        input logic [3:0] tv, input logic [3:0] ts, input logic [7:0] tc,
                        input logic [3:0] rv, input logic [3:0] rs, input logic [7:0] rc);
        start = st; stop = sp;
        tx_vld = tv; tx_sop = ts; tx_cls = tc;
        rx_vld = rv; rx_sop = rs; rx_cls = rc;
        if (st) begin
            m.cyc = 0; m.txf = 0; m.rxf = 0; m.txb = 0; m.rxb = 0;
            for (int k = 0; k < 4; k++) begin m.txr[k] = 0; m.rxr[k] = 0; end
            m.run = 1; m.dn = 0;
        end else if (m.run && sp) begin
            m.run = 0; m.dn = 1;
        end else if (m.run) begin
            model_dir(tv, ts, tc, m.txf, m.txb, m.txr);
            model_dir(rv, rs, rc, m.rxf, m.rxb, m.rxr);
            m.cyc = sat(m.cyc, 1);
            if (limit_en && m.cyc >= longint'(cycle_limit)) begin
                m.run = 0; m.dn = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        start = 0; stop = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 4'hF, 4'h0, 8'h00, 4'hF, 4'h0, 8'h00);
    endtask

    // Driver side: push the expected item for the monitor
    task automatic expect_now(input string tag);
        exp_t e;
        e = m;
        e.tag = tag;
        sbq.push_back(e);
        #1;
    endtask

    // Monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            exp_t e;
            wait (sbq.size() > 0);
            e = sbq.pop_front();
            chk({e.tag, " running"}, longint'(running), longint'(e.run));
            chk({e.tag, " done"}, longint'(done), longint'(e.dn));
            chk({e.tag, " cycles"}, cycle_cnt, e.cyc);
            chk({e.tag, " tx flits"}, tx_flit_cnt, e.txf);
            chk({e.tag, " rx flits"}, rx_flit_cnt, e.rxf);
            chk({e.tag, " tx bits"}, tx_bit_cnt, e.txb);
            chk({e.tag, " rx bits"}, rx_bit_cnt, e.rxb);
            for (int k = 0; k < 4; k++) begin
                chk($sformatf("%s tx req class %0d", e.tag, k), tx_req_cnt[k*W +: W], e.txr[k]);
                chk($sformatf("%s rx req class %0d", e.tag, k), rx_req_cnt[k*W +: W], e.rxr[k]);
            end
        end
    end

    initial begin
        m.cyc = 0; m.txf = 0; m.rxf = 0; m.txb = 0; m.rxb = 0;
        for (int k = 0; k < 4; k++) begin m.txr[k] = 0; m.rxr[k] = 0; end
        m.run = 0; m.dn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        expect_now("R1 reset");

        // Boundary beats carry traffic; invalid lane with sop; mixed classes
        step(1, 0, 4'hF, 4'hF, 8'hFF, 4'hF, 4'hF, 8'hFF);
        step(0, 0, 4'b1011, 4'b0001, 8'b00_00_00_11, 4'b0001, 4'b0001, 8'h00);
        step(0, 0, 4'b0100, 4'b1100, 8'b10_01_00_00, 4'b0000, 4'b0000, 8'h00);
        step(0, 0, 4'b0000, 4'b0000, 8'h00, 4'b0011, 4'b0010, 8'b0000_10_00);
        step(0, 0, 4'hF, 4'b0101, 8'b00_10_00_01, 4'hF, 4'hF, 8'b11_10_01_00);
        step(0, 1, 4'hF, 4'hF, 8'hFF, 4'hF, 4'hF, 8'hFF);
        expect_now("R3 R4 R5 R6 R7 window totals");

        // Closed window: stop and traffic have no effect
        step(0, 1, 4'hF, 4'hF, 8'hAA, 4'hF, 4'hF, 8'h55);
        step(0, 0, 4'hF, 4'hF, 8'hAA, 4'hF, 4'hF, 8'h55);
        expect_now("R7 frozen after stop");

        // Limited window of 5 cycles
        limit_en = 1; cycle_limit = 48'd5;
        step(1, 0, 4'h0, 4'h0, 8'h00, 4'h0, 4'h0, 8'h00);
        for (int i = 0; i < 7; i++) step(0, 0, 4'hF, 4'b0011, 8'b0000_11_10, 4'b0001, 4'b0001, 8'h01);
        expect_now("R8 limit of 5");

        // Limit of zero behaves as one
        cycle_limit = 48'd0;
        step(1, 0, 4'h0, 4'h0, 8'h00, 4'h0, 4'h0, 8'h00);
        for (int i = 0; i < 3; i++) step(0, 0, 4'b0001, 4'b0001, 8'h03, 4'h0, 4'h0, 8'h00);
        expect_now("R8 limit of zero");
        limit_en = 0;

        // Restart in an open window and start with stop together
        step(1, 0, 4'h0, 4'h0, 8'h00, 4'h0, 4'h0, 8'h00);
        step(0, 0, 4'hF, 4'hF, 8'h00, 4'h0, 4'h0, 8'h00);
        step(0, 0, 4'hF, 4'hF, 8'h00, 4'h0, 4'h0, 8'h00);
        step(1, 0, 4'hF, 4'hF, 8'hFF, 4'h0, 4'h0, 8'h00);
        step(0, 0, 4'b0010, 4'b0010, 8'b0000_01_00, 4'h0, 4'h0, 8'h00);
        expect_now("R2 restart clears");
        step(1, 1, 4'hF, 4'hF, 8'hFF, 4'hF, 4'hF, 8'hFF);
        expect_now("R2 start beats stop");

        // Receive-only traffic
        step(0, 0, 4'h0, 4'h0, 8'h00, 4'hF, 4'b1001, 8'b11_00_00_10);
        step(0, 0, 4'h0, 4'hF, 8'hFF, 4'b0110, 4'b0100, 8'b00_01_00_00);
        step(0, 1, 4'h0, 4'h0, 8'h00, 4'h0, 4'h0, 8'h00);
        expect_now("R10 rx only");
        idle(1);

        // Saturation on the narrow instance
        s_start = 1;
        @(posedge clk); @(negedge clk);
        s_start = 0; s_vld = 4'hF; s_sop = 4'hF; s_cls = 8'hFF;
        @(posedge clk); @(negedge clk);
        chk("R9 bits saturate", s_txb, 64'd4095);
        chk("R9 flits first beat", s_txf, 64'd4);
        chk("R9 class 3 requests", s_txr[3*SW +: SW], 64'd4);
        @(posedge clk); @(negedge clk);
        chk("R9 bits stay at max", s_txb, 64'd4095);
        s_vld = 0; s_sop = 0; s_cls = 0;

        #1;
        wait (sbq.size() == 0);
        #1;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule